// File: doc/BRIEF.md
# Dual-Port Synchronous Word RAM

This block is a true dual-port static memory of 36-bit words, each word split into four 9-bit byte lanes. A left port and a right port each have their own clock, and each registers its address, control and write data on its own rising edge. Either port can read or write any word at any time, including the word the other port is touching. The read path of each port is selected at run time by a mode input: flow-through (data follows the sampling edge in the same cycle) or pipelined (one extra output register, so data follows one edge later).

Each port has an active-low chip enable, an active-low write strobe (low writes, high reads), four active-low lane selects that mask both writes and reads, and an active-low output enable that gates the read drivers without regard to the clock. The data bus is modelled as a read-data output plus one drive-enable bit per lane; a lane that is not driven reads as zero. The storage is held as one bank per port with a per-lane ownership bit, so each bank has a single writer and clock.

Top module: `dpram_core`

## Requirements
- R1: While rst_ni is low, and after reset before any read is sampled, both ports drive no lane (drive_o = 0, rdata_o = 0).
- R2: A write (ce_ni low, we_ni low, sampled on the port edge) stores only the lanes whose lane_ni bit is low; lane k covers bits 9k+8 down to 9k, and unselected lanes keep their old contents.
- R3: With pipe_i low, a read sampled at edge k drives its selected lanes with the stored word from edge k until edge k+1.
- R4: With pipe_i high, a read sampled at edge k is driven from edge k+1 to edge k+2; between edges k and k+1 the port shows what the previous sample called for.
- R5: oe_ni high forces every drive bit and all read data to zero at once, without a clock edge, and releasing it restores the read drivers at once.
- R6: On a read, lanes whose lane_ni bit is high are not driven and read as zero.
- R7: ce_ni high deselects the port: in flow-through mode the drivers turn off after the sampling edge; in pipelined mode they turn off one edge later.
- R8: A write sampled at edge k is committed at the port's next edge k+1; a read on either port sampled at or after the commit edge returns the new data, a read sampled at edge k returns the old data.
- R9: When both ports commit writes to the same word on the same edge, each lane selected by the left port holds the left data, lanes selected only by the right port hold the right data.
- R10: A write cycle never drives the data lanes of that port.
- R11: A cycle sampled with ce_ni high leaves the memory unchanged even when we_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l_i | input | 1 | Left port clock |
| clk_r_i | input | 1 | Right port clock |
| rst_ni | input | 1 | Asynchronous active-low reset of port registers |
| l_ce_ni | input | 1 | Left chip enable, active low |
| l_we_ni | input | 1 | Left write strobe, low writes, high reads |
| l_oe_ni | input | 1 | Left output enable, active low, unclocked |
| l_lane_ni | input | 4 | Left byte-lane selects, active low |
| l_pipe_i | input | 1 | Left read mode, 1 pipelined, 0 flow-through |
| l_addr_i | input | AW | Left word address |
| l_wdata_i | input | 36 | Left write data |
| l_rdata_o | output | 36 | Left read data, zero on undriven lanes |
| l_drive_o | output | 4 | Left per-lane drive enable |
| r_ce_ni | input | 1 | Right chip enable, active low |
| r_we_ni | input | 1 | Right write strobe, low writes, high reads |
| r_oe_ni | input | 1 | Right output enable, active low, unclocked |
| r_lane_ni | input | 4 | Right byte-lane selects, active low |
| r_pipe_i | input | 1 | Right read mode, 1 pipelined, 0 flow-through |
| r_addr_i | input | AW | Right word address |
| r_wdata_i | input | 36 | Right write data |
| r_rdata_o | output | 36 | Right read data, zero on undriven lanes |
| r_drive_o | output | 4 | Right per-lane drive enable |

## Verification
A corrupted ownership bit shows as a whole lane returning the other bank's stale data on the very next read of that word, so the bench fills the whole array from one port and reads every word back through the other. A stuck or skipped output register shows as data arriving one edge early or late, or drivers lingering one edge after deselect, visible in the cycle right after the sampling edge. A lost write mask shows as lanes changed that the writer did not select, caught by partial-lane writes over a known pattern.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int NUM_LANES = 4;
  localparam int LANE_W    = 9;
  localparam int WORD_W    = NUM_LANES * LANE_W;
  localparam int LANE_IW   = $clog2(NUM_LANES);

  typedef logic [WORD_W-1:0]    word_t;
  typedef logic [NUM_LANES-1:0] lanes_t;

  typedef struct packed {
    logic   sel;
    logic   rd;
    lanes_t lane;
  } req_ctl_t;

  function automatic word_t lane_mask(input lanes_t en, input word_t w);
    word_t m;
    for (int i = 0; i < NUM_LANES; i++)
      m[i*LANE_W +: LANE_W] = en[i] ? w[i*LANE_W +: LANE_W] : '0;
    return m;
  endfunction
endpackage

// File: rtl/dpram_port.sv
module dpram_port
  import dpram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  lanes_t        lane_ni,
  input  logic          pipe_i,
  input  logic [AW-1:0] addr_i,
  input  word_t         wdata_i,
  input  word_t         rd_word_i,
  output logic [AW-1:0] addr_o,
  output word_t         wdata_o,
  output lanes_t        wr_lane_o,
  output word_t         rdata_o,
  output lanes_t        drive_o
);
  req_ctl_t      ctl_q;
  logic [AW-1:0] addr_q;
  word_t         wdata_q;
  lanes_t        pipe_en_q;
  word_t         pipe_data_q;
  lanes_t        flow_en;
  lanes_t        out_en;
  word_t         out_data;

  // input registers, always present
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      ctl_q.sel  <= ~ce_ni;
      ctl_q.rd   <= we_ni;
      ctl_q.lane <= ~lane_ni;
      addr_q     <= addr_i;
      wdata_q    <= wdata_i;
    end
  end

  assign flow_en   = (ctl_q.sel && ctl_q.rd)  ? ctl_q.lane : '0;
  assign wr_lane_o = (ctl_q.sel && !ctl_q.rd) ? ctl_q.lane : '0;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;

  // output register used only in pipelined mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_en_q   <= '0;
      pipe_data_q <= '0;
    end else begin
      pipe_en_q   <= flow_en;
      pipe_data_q <= rd_word_i;
    end
  end

  assign out_en   = pipe_i ? pipe_en_q   : flow_en;
  assign out_data = pipe_i ? pipe_data_q : rd_word_i;
  assign drive_o  = oe_ni ? '0 : out_en;
  assign rdata_o  = lane_mask(drive_o, out_data);
endmodule

// File: rtl/dpram_bank.sv
module dpram_bank
  import dpram_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter bit IS_LEFT = 1'b1,
  localparam int AW     = $clog2(DEPTH),
  localparam int TOG_N  = DEPTH * NUM_LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  lanes_t           wr_lane_i,
  input  logic [AW-1:0]    waddr_i,
  input  word_t            wdata_i,
  input  logic [TOG_N-1:0] peer_tog_i,
  output logic [TOG_N-1:0] tog_o,
  input  logic [AW-1:0]    raddr_l_i,
  input  logic [AW-1:0]    raddr_r_i,
  output word_t            rd_l_o,
  output word_t            rd_r_o
);
  word_t            mem [DEPTH];
  logic [TOG_N-1:0] tog_q;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam logic [LANE_IW-1:0] LIDX = LANE_IW'(g);

    always_ff @(posedge clk_i) begin
      if (wr_lane_i[g]) mem[waddr_i][g*LANE_W +: LANE_W] <= wdata_i[g*LANE_W +: LANE_W];
    end

    // ownership: left makes the xor 0, right makes it 1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int d = 0; d < DEPTH; d++) tog_q[d*NUM_LANES + g] <= 1'b0;
      end else if (wr_lane_i[g]) begin
        tog_q[{waddr_i, LIDX}] <= IS_LEFT ? peer_tog_i[{waddr_i, LIDX}]
                                          : ~peer_tog_i[{waddr_i, LIDX}];
      end
    end
  end

  assign tog_o  = tog_q;
  assign rd_l_o = mem[raddr_l_i];
  assign rd_r_o = mem[raddr_r_i];
endmodule

// File: rtl/dpram_core.sv
module dpram_core
  import dpram_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk_l_i,
  input  logic                 clk_r_i,
  input  logic                 rst_ni,
  input  logic                 l_ce_ni,
  input  logic                 l_we_ni,
  input  logic                 l_oe_ni,
  input  logic [NUM_LANES-1:0] l_lane_ni,
  input  logic                 l_pipe_i,
  input  logic [AW-1:0]        l_addr_i,
  input  logic [WORD_W-1:0]    l_wdata_i,
  output logic [WORD_W-1:0]    l_rdata_o,
  output logic [NUM_LANES-1:0] l_drive_o,
  input  logic                 r_ce_ni,
  input  logic                 r_we_ni,
  input  logic                 r_oe_ni,
  input  logic [NUM_LANES-1:0] r_lane_ni,
  input  logic                 r_pipe_i,
  input  logic [AW-1:0]        r_addr_i,
  input  logic [WORD_W-1:0]    r_wdata_i,
  output logic [WORD_W-1:0]    r_rdata_o,
  output logic [NUM_LANES-1:0] r_drive_o
);
  localparam int TOG_N = DEPTH * NUM_LANES;

  logic [AW-1:0]    l_addr_q, r_addr_q;
  word_t            l_wdata_q, r_wdata_q;
  lanes_t           l_wr_lane, r_wr_lane, r_wr_eff;
  word_t            l_word, r_word;
  logic [TOG_N-1:0] tog_l, tog_r;
  word_t            bl_rd_l, bl_rd_r, br_rd_l, br_rd_r;

  dpram_port #(.AW(AW)) u_port_l (
    .clk_i(clk_l_i), .rst_ni(rst_ni), .ce_ni(l_ce_ni), .we_ni(l_we_ni),
    .oe_ni(l_oe_ni), .lane_ni(l_lane_ni), .pipe_i(l_pipe_i),
    .addr_i(l_addr_i), .wdata_i(l_wdata_i), .rd_word_i(l_word),
    .addr_o(l_addr_q), .wdata_o(l_wdata_q), .wr_lane_o(l_wr_lane),
    .rdata_o(l_rdata_o), .drive_o(l_drive_o)
  );

  dpram_port #(.AW(AW)) u_port_r (
    .clk_i(clk_r_i), .rst_ni(rst_ni), .ce_ni(r_ce_ni), .we_ni(r_we_ni),
    .oe_ni(r_oe_ni), .lane_ni(r_lane_ni), .pipe_i(r_pipe_i),
    .addr_i(r_addr_i), .wdata_i(r_wdata_i), .rd_word_i(r_word),
    .addr_o(r_addr_q), .wdata_o(r_wdata_q), .wr_lane_o(r_wr_lane),
    .rdata_o(r_rdata_o), .drive_o(r_drive_o)
  );

  // same word, same edge: left keeps its lanes
  assign r_wr_eff = (l_addr_q == r_addr_q) ? (r_wr_lane & ~l_wr_lane) : r_wr_lane;

  dpram_bank #(.DEPTH(DEPTH), .IS_LEFT(1'b1)) u_bank_l (
    .clk_i(clk_l_i), .rst_ni(rst_ni), .wr_lane_i(l_wr_lane),
    .waddr_i(l_addr_q), .wdata_i(l_wdata_q), .peer_tog_i(tog_r),
    .tog_o(tog_l), .raddr_l_i(l_addr_q), .raddr_r_i(r_addr_q),
    .rd_l_o(bl_rd_l), .rd_r_o(bl_rd_r)
  );

  dpram_bank #(.DEPTH(DEPTH), .IS_LEFT(1'b0)) u_bank_r (
    .clk_i(clk_r_i), .rst_ni(rst_ni), .wr_lane_i(r_wr_eff),
    .waddr_i(r_addr_q), .wdata_i(r_wdata_q), .peer_tog_i(tog_l),
    .tog_o(tog_r), .raddr_l_i(l_addr_q), .raddr_r_i(r_addr_q),
    .rd_l_o(br_rd_l), .rd_r_o(br_rd_r)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_rmux
    localparam logic [LANE_IW-1:0] LIDX = LANE_IW'(g);
    logic own_l, own_r;
    assign own_l = tog_l[{l_addr_q, LIDX}] ^ tog_r[{l_addr_q, LIDX}];
    assign own_r = tog_l[{r_addr_q, LIDX}] ^ tog_r[{r_addr_q, LIDX}];
    assign l_word[g*LANE_W +: LANE_W] = own_l ? br_rd_l[g*LANE_W +: LANE_W]
                                              : bl_rd_l[g*LANE_W +: LANE_W];
    assign r_word[g*LANE_W +: LANE_W] = own_r ? br_rd_r[g*LANE_W +: LANE_W]
                                              : bl_rd_r[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/dpram_core_chk.sv
module dpram_core_chk #(
  parameter int NL = 4
) (
  input logic          clk_l_i,
  input logic          clk_r_i,
  input logic          rst_ni,
  input logic          l_ce_ni,
  input logic          l_we_ni,
  input logic          l_oe_ni,
  input logic [NL-1:0] l_lane_ni,
  input logic          l_pipe_i,
  input logic [NL-1:0] l_drive_o,
  input logic          r_ce_ni,
  input logic          r_we_ni,
  input logic [NL-1:0] r_drive_o
);
  always_comb begin
    if (!rst_ni) a_r1_quiet_in_reset: assert (l_drive_o == '0 && r_drive_o == '0);
  end

  always_comb begin
    if (rst_ni && l_oe_ni) a_r5_oe_blocks: assert (l_drive_o == '0);
  end

  a_r6_lane_off: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    (l_lane_ni == '1) |=> (l_pipe_i || l_drive_o == '0));

  a_r7_desel_flow: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    l_ce_ni |=> (l_pipe_i || l_drive_o == '0));

  a_r7_desel_two: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    (l_ce_ni && $past(l_ce_ni)) |=> (l_drive_o == '0));

  a_r10_write_quiet: assert property (@(posedge clk_l_i) disable iff (!rst_ni)
    (!l_we_ni && $past(!l_we_ni || l_ce_ni)) |=> (l_drive_o == '0));

  a_r10_write_quiet_r: assert property (@(posedge clk_r_i) disable iff (!rst_ni)
    (!r_we_ni && $past(!r_we_ni || r_ce_ni) && $past(!r_ce_ni || r_ce_ni)) |=> (r_drive_o == '0));
endmodule

bind dpram_core dpram_core_chk #(.NL(dpram_pkg::NUM_LANES)) u_chk (
  .clk_l_i(clk_l_i), .clk_r_i(clk_r_i), .rst_ni(rst_ni),
  .l_ce_ni(l_ce_ni), .l_we_ni(l_we_ni), .l_oe_ni(l_oe_ni),
  .l_lane_ni(l_lane_ni), .l_pipe_i(l_pipe_i), .l_drive_o(l_drive_o),
  .r_ce_ni(r_ce_ni), .r_we_ni(r_we_ni), .r_drive_o(r_drive_o)
);

// File: tb/tb_dpram_core.sv
module tb_dpram_core;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 0;
  logic rst_ni = 0;
  logic l_ce_ni = 1, l_we_ni = 1, l_oe_ni = 0, l_pipe_i = 0;
  logic r_ce_ni = 1, r_we_ni = 1, r_oe_ni = 0, r_pipe_i = 0;
  logic [3:0] l_lane_ni = 4'hF, r_lane_ni = 4'hF;
  logic [AW-1:0] l_addr_i = '0, r_addr_i = '0;
  logic [35:0] l_wdata_i = '0, r_wdata_i = '0;
  logic [35:0] l_rdata_o, r_rdata_o;
  logic [3:0]  l_drive_o, r_drive_o;

  int checks = 0, errors = 0;
  logic [35:0] mdl [DEPTH];
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpram_core #(.DEPTH(DEPTH)) dut (
    .clk_l_i(clk), .clk_r_i(clk), .rst_ni(rst_ni),
    .l_ce_ni(l_ce_ni), .l_we_ni(l_we_ni), .l_oe_ni(l_oe_ni), .l_lane_ni(l_lane_ni),
    .l_pipe_i(l_pipe_i), .l_addr_i(l_addr_i), .l_wdata_i(l_wdata_i),
    .l_rdata_o(l_rdata_o), .l_drive_o(l_drive_o),
    .r_ce_ni(r_ce_ni), .r_we_ni(r_we_ni), .r_oe_ni(r_oe_ni), .r_lane_ni(r_lane_ni),
    .r_pipe_i(r_pipe_i), .r_addr_i(r_addr_i), .r_wdata_i(r_wdata_i),
    .r_rdata_o(r_rdata_o), .r_drive_o(r_drive_o)
  );

  // {addr, lane select (active high), data}
  localparam logic [43:0] VEC [6] = '{
    {4'd1,  4'b0001, 36'h1_2345_6789},
    {4'd2,  4'b1000, 36'hF_0F0F_0F0F},
    {4'd3,  4'b0110, 36'hA_AAAA_AAAA},
    {4'd8,  4'b1111, 36'h5_5555_5555},
    {4'd12, 4'b1010, 36'h3_C3C3_C3C3},
    {4'd15, 4'b0101, 36'hE_DCBA_9876}
  };

  function automatic logic [35:0] msk(input logic [3:0] en, input logic [35:0] w);
    logic [35:0] m;
    for (int i = 0; i < 4; i++) m[i*9 +: 9] = en[i] ? w[i*9 +: 9] : 9'h0;
    return m;
  endfunction

  function automatic logic [35:0] merge(input logic [3:0] en, input logic [35:0] nw,
                                        input logic [35:0] od);
    return msk(en, nw) | msk(~en, od);
  endfunction

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic set_l(input logic sel, input logic wr, input logic [3:0] ln,
                       input logic pp, input logic [AW-1:0] a, input logic [35:0] d);
    l_ce_ni = ~sel; l_we_ni = ~wr; l_lane_ni = ~ln; l_pipe_i = pp; l_addr_i = a; l_wdata_i = d;
  endtask

  task automatic set_r(input logic sel, input logic wr, input logic [3:0] ln,
                       input logic pp, input logic [AW-1:0] a, input logic [35:0] d);
    r_ce_ni = ~sel; r_we_ni = ~wr; r_lane_ni = ~ln; r_pipe_i = pp; r_addr_i = a; r_wdata_i = d;
  endtask

  task automatic chk(input bit right, input logic [3:0] edrv, input logic [35:0] edat,
                     input string req);
    logic [3:0] drv;
    logic [35:0] dat;
    drv = right ? r_drive_o : l_drive_o;
    dat = right ? r_rdata_o : l_rdata_o;
    checks++;
    if (drv !== edrv || dat !== msk(edrv, edat)) begin
      errors++;
      $display("FAIL %s port=%0d drive=%h data=%h expected drive=%h data=%h",
               req, right, drv, dat, edrv, msk(edrv, edat));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk(0, 4'h0, '0, "R1 in reset left");
    chk(1, 4'h0, '0, "R1 in reset right");
    rst_ni = 1;
    tick();
    chk(0, 4'h0, '0, "R1 after reset left");
    chk(1, 4'h0, '0, "R1 after reset right");

    // fill whole array from left, read back from right flow-through (R2 R3 R8)
    for (int i = 0; i < DEPTH; i++) begin
      mdl[i] = {4'(i), 32'hA5C3_0000 + 32'(i * 7919)};
      set_l(1, 1, 4'hF, 0, AW'(i), mdl[i]);
      tick();
    end
    set_l(0, 0, 4'h0, 0, '0, '0);
    for (int i = 0; i < DEPTH; i++) begin
      set_r(1, 0, 4'hF, 0, AW'(i), '0);
      tick();
      chk(1, 4'hF, mdl[i], "R3 R8 fill readback");
    end
    set_r(0, 0, 4'h0, 0, '0, '0);
    tick();

    // table: partial-lane writes, pipelined readback (R2 R4)
    for (int v = 0; v < 6; v++) begin
      logic [AW-1:0] a;
      a = VEC[v][43:40];
      set_l(1, 1, VEC[v][39:36], 0, a, VEC[v][35:0]);
      tick();
      mdl[a] = merge(VEC[v][39:36], VEC[v][35:0], mdl[a]);
      set_l(0, 0, 4'h0, 0, '0, '0);
      set_r(1, 0, 4'hF, 1, a, '0);
      tick();
      chk(1, 4'h0, '0, "R4 pipelined not yet");
      set_r(0, 0, 4'h0, 1, '0, '0);
      tick();
      chk(1, 4'hF, mdl[a], "R2 R4 masked write pipelined read");
    end
    set_r(0, 0, 4'h0, 0, '0, '0);
    tick();

    // R5 output enable, asynchronous
    r_oe_ni = 1;
    set_r(1, 0, 4'hF, 0, 4'd2, '0);
    tick();
    chk(1, 4'h0, '0, "R5 oe high blocks");
    r_oe_ni = 0;
    #1;
    chk(1, 4'hF, mdl[2], "R5 oe low restores without edge");

    // R6 read lane selects
    set_r(1, 0, 4'b0101, 0, 4'd4, '0);
    tick();
    chk(1, 4'b0101, mdl[4], "R6 read lane mask");
    set_r(0, 0, 4'h0, 0, '0, '0);

    // R7 pipelined deselect one edge late
    set_l(1, 0, 4'hF, 1, 4'd6, '0);
    tick();
    chk(0, 4'h0, '0, "R7 pipe first edge");
    set_l(0, 0, 4'h0, 1, '0, '0);
    tick();
    chk(0, 4'hF, mdl[6], "R7 pipe still driving after deselect sample");
    tick();
    chk(0, 4'h0, '0, "R7 pipe off one edge later");
    // R7 flow-through deselect immediate
    set_l(1, 0, 4'hF, 0, 4'd7, '0);
    tick();
    chk(0, 4'hF, mdl[7], "R7 flow read");
    set_l(0, 0, 4'h0, 0, '0, '0);
    tick();
    chk(0, 4'h0, '0, "R7 flow off at once");

    // R10 write cycle does not drive
    set_l(1, 1, 4'hF, 0, 4'd9, 36'h9_8765_4321);
    tick();
    chk(0, 4'h0, '0, "R10 write cycle quiet");
    mdl[9] = 36'h9_8765_4321;

    // R11 deselected write ignored
    set_l(0, 1, 4'hF, 0, 4'd9, 36'h0_DEAD_BEEF);
    tick();
    set_l(0, 0, 4'h0, 0, '0, '0);
    tick();
    set_r(1, 0, 4'hF, 0, 4'd9, '0);
    tick();
    chk(1, 4'hF, mdl[9], "R11 deselected write ignored");

    // R8 cross-port commit timing
    set_l(1, 1, 4'hF, 0, 4'd5, 36'h7_1111_2222);
    set_r(1, 0, 4'hF, 0, 4'd5, '0);
    tick();
    chk(1, 4'hF, mdl[5], "R8 same-edge read sees old");
    mdl[5] = 36'h7_1111_2222;
    set_l(0, 0, 4'h0, 0, '0, '0);
    tick();
    chk(1, 4'hF, mdl[5], "R8 commit-edge read sees new");

    // R9 collision: left wins on overlapping lanes
    set_l(1, 1, 4'b0011, 0, 4'd11, 36'h1_1111_1111);
    set_r(1, 1, 4'b0110, 0, 4'd11, 36'h2_2222_2222);
    tick();
    mdl[11] = merge(4'b0110, 36'h2_2222_2222, mdl[11]);
    mdl[11] = merge(4'b0011, 36'h1_1111_1111, mdl[11]);
    set_l(0, 0, 4'h0, 0, '0, '0);
    set_r(0, 0, 4'h0, 0, '0, '0);
    tick();
    set_r(1, 0, 4'hF, 0, 4'd11, '0);
    set_l(1, 0, 4'hF, 0, 4'd11, '0);
    tick();
    chk(1, 4'hF, mdl[11], "R9 collision right view");
    chk(0, 4'hF, mdl[11], "R9 collision left view");
    set_l(0, 0, 4'h0, 0, '0, '0);
    set_r(0, 0, 4'h0, 0, '0, '0);
    tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule